// File: doc/BRIEF.md
# Asynchronous SRAM/NOR Access Sequencer

This block turns single requests from an on-chip master into timed, asynchronous accesses to an external SRAM or NOR style device. A request carries a direction, an address, write data and byte enables. It is taken when `req_ready` is high. The block then steps through up to four timed phases: address setup, address hold (used only on a shared address/data bus), data, and bus turnaround. Each phase length is set by a configuration input counted in system clock cycles. The strobes to the device are active low and come straight from flops.

When the shared-bus option is on, the low address bits are placed on the data pins during setup and hold, and an address-latch strobe pulses low for the setup phase. The device can stretch the data phase through a wait input. The level at which wait counts as asserted can be selected, and wait can be ignored entirely. Read data is captured on the final data cycle and returned together with a one-cycle completion pulse. Writes are refused, with an error completion, unless the write-permit input is set.

Top module: `amem_seq_top`

## Requirements
- R1: After reset, and at once when reset is asserted mid-access, `mem_cs_n`, `mem_oe_n`, `mem_we_n` and `mem_adv_n` are 1, `mem_dq_oe` and `rsp_done` are 0, and `req_ready` is 1.
- R2: An accepted access holds `mem_cs_n` low for exactly S + H' + D' + W cycles. S is `cfg_addr_setup` (0 skips the phase). H' is max(`cfg_addr_hold`,1) when `cfg_mux`=1 and 0 otherwise. D' is max(`cfg_data_setup`,1). W is the stall count from R9.
- R3: With `cfg_mux`=1, `mem_adv_n` is low for exactly the S setup cycles, with `mem_dq_oe`=1 and `mem_dq_out` equal to the request address bits [DATA_W-1:0]. With `cfg_mux`=0, `mem_adv_n` never goes low.
- R4: For a read, `mem_oe_n` is low for exactly D'+W cycles and `mem_dq_oe` is 0 during them. For a write, `mem_we_n` is low for exactly D'+W cycles. `mem_oe_n` and `mem_we_n` are never low together.
- R5: `rsp_done` is high for one cycle, in the cycle right after the last data cycle. For a read, `rsp_rdata` then equals the `mem_dq_in` value present on the last cycle that `mem_oe_n` was low.
- R6: During a write data phase, `mem_dq_oe`=1 and `mem_dq_out` equals the write data. While `mem_cs_n` is low, `mem_be_n` equals the bitwise inverse of `req_be`.
- R7: After a completed access, `req_ready` stays low for exactly `cfg_turnaround` cycles, counted from the `rsp_done` cycle. With 0, it is high in the `rsp_done` cycle.
- R8: A write request taken while `cfg_wr_en`=0 is answered in the next cycle with `rsp_done`=1 and `rsp_err`=1. No strobe goes low and `req_ready` is not lowered.
- R9: With `cfg_wait_en`=1, every data-phase cycle in which `mem_wait` equals `cfg_wait_pol` (1 = active high) adds one cycle to the data phase (W = number of such cycles). With `cfg_wait_en`=0, `mem_wait` has no effect (W = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mux | input | 1 | 1: address shares the data pins |
| cfg_wr_en | input | 1 | 1: writes may reach the device |
| cfg_wait_en | input | 1 | 1: wait input may stretch the data phase |
| cfg_wait_pol | input | 1 | Asserted level of the wait input |
| cfg_addr_setup | input | 4 | Address setup cycles, 0 to 15 |
| cfg_addr_hold | input | 4 | Address hold cycles, 1 to 15 (0 acts as 1) |
| cfg_data_setup | input | 8 | Data phase cycles, 1 to 255 (0 acts as 1) |
| cfg_turnaround | input | 4 | Idle gap after an access, 0 to 15 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion refused (write not permitted) |
| rsp_rdata | output | DATA_W | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address latch strobe, active low |
| mem_be_n | output | DATA_W/8 | Byte lane selects, active low |
| mem_addr | output | ADDR_W | Address pins |
| mem_dq_out | output | DATA_W | Data pins, outgoing value |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W | Data pins, incoming value |
| mem_wait | input | 1 | Wait from the device |

## Verification
The hardest case to reach is a wait assertion that lands in the final planned cycle of the data phase. That is the only point where a counter that freezes badly would still complete on time. The bench plays the device side. It raises wait on the falling edge after each data-phase cycle begins, and holds it for a set number of cycles. It does this with one- and two-cycle data phases, so the stall always covers the expiring cycle, and repeats it with wait disabled to show the input is ignored. The device model drives read data only while output enable is low. A capture taken one cycle late then shows up as a wrong read value.

// File: rtl/amem_pkg.sv
package amem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_HOLD  = 3'd2,
        PH_DATA  = 3'd3,
        PH_TURN  = 3'd4
    } amem_phase_e;

endpackage

// File: rtl/amem_wait_qual.sv
module amem_wait_qual (
    input  logic enable,
    input  logic active_level,
    input  logic wait_in,
    output logic stall
);

    always_comb begin
        stall = enable && (wait_in == active_level);
    end

endmodule

// File: rtl/amem_phase_timer.sv
module amem_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/amem_seq_top.sv
module amem_seq_top #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int APH_W  = 4,
    parameter int DPH_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_mux,
    input  logic                   cfg_wr_en,
    input  logic                   cfg_wait_en,
    input  logic                   cfg_wait_pol,
    input  logic [APH_W-1:0]       cfg_addr_setup,
    input  logic [APH_W-1:0]       cfg_addr_hold,
    input  logic [DPH_W-1:0]       cfg_data_setup,
    input  logic [APH_W-1:0]       cfg_turnaround,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_be,
    output logic                   rsp_done,
    output logic                   rsp_err,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   mem_cs_n,
    output logic                   mem_oe_n,
    output logic                   mem_we_n,
    output logic                   mem_adv_n,
    output logic [DATA_W/8-1:0]    mem_be_n,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in,
    input  logic                   mem_wait
);

    import amem_pkg::*;

    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = (DPH_W > APH_W) ? DPH_W : APH_W;

    typedef struct packed {
        amem_phase_e       ph;
        logic              wr;
        logic              mux;
        logic [APH_W-1:0]  hold;
        logic [DPH_W-1:0]  dset;
        logic [APH_W-1:0]  turn;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic              cs_n;
        logic              oe_n;
        logic              we_n;
        logic              adv_n;
        logic              dq_oe;
        logic [DATA_W-1:0] dq_out;
        logic [BE_W-1:0]   be_n;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_run;
    logic             tmr_expired;
    logic             wait_hit;
    logic             stall;

    function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : (v - CNT_W'(1));
    endfunction

    amem_wait_qual u_wait (
        .enable       (cfg_wait_en),
        .active_level (cfg_wait_pol),
        .wait_in      (mem_wait),
        .stall        (wait_hit)
    );

    amem_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    assign stall = wait_hit && (s_q.ph == PH_DATA);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_run  = 1'b0;

        case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_write && !cfg_wr_en) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else begin
                        s_d.wr    = req_write;
                        s_d.mux   = cfg_mux;
                        s_d.hold  = cfg_addr_hold;
                        s_d.dset  = cfg_data_setup;
                        s_d.turn  = cfg_turnaround;
                        s_d.addr  = req_addr;
                        s_d.wdata = req_wdata;
                        s_d.be    = req_be;
                        tmr_load  = 1'b1;
                        if (cfg_addr_setup != '0) begin
                            s_d.ph  = PH_SETUP;
                            tmr_val = len_m1(CNT_W'(cfg_addr_setup));
                        end else if (cfg_mux) begin
                            s_d.ph  = PH_HOLD;
                            tmr_val = len_m1(CNT_W'(cfg_addr_hold));
                        end else begin
                            s_d.ph  = PH_DATA;
                            tmr_val = len_m1(CNT_W'(cfg_data_setup));
                        end
                    end
                end
            end
            PH_SETUP: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (s_q.mux) begin
                        s_d.ph  = PH_HOLD;
                        tmr_val = len_m1(CNT_W'(s_q.hold));
                    end else begin
                        s_d.ph  = PH_DATA;
                        tmr_val = len_m1(CNT_W'(s_q.dset));
                    end
                end
            end
            PH_HOLD: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    s_d.ph   = PH_DATA;
                    tmr_val  = len_m1(CNT_W'(s_q.dset));
                end
            end
            PH_DATA: begin
                tmr_run = !stall;
                if (tmr_expired && !stall) begin
                    s_d.done = 1'b1;
                    if (!s_q.wr) begin
                        s_d.rdata = mem_dq_in;
                    end
                    if (s_q.turn != '0) begin
                        s_d.ph   = PH_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = len_m1(CNT_W'(s_q.turn));
                    end else begin
                        s_d.ph = PH_IDLE;
                    end
                end
            end
            PH_TURN: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    s_d.ph = PH_IDLE;
                end
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase

        s_d.cs_n  = !((s_d.ph == PH_SETUP) || (s_d.ph == PH_HOLD) || (s_d.ph == PH_DATA));
        s_d.adv_n = !(s_d.mux && (s_d.ph == PH_SETUP));
        s_d.oe_n  = !((s_d.ph == PH_DATA) && !s_d.wr);
        s_d.we_n  = !((s_d.ph == PH_DATA) && s_d.wr);
        if (s_d.mux) begin
            s_d.dq_oe = (s_d.ph == PH_SETUP) || (s_d.ph == PH_HOLD) ||
                        ((s_d.ph == PH_DATA) && s_d.wr);
        end else begin
            s_d.dq_oe = s_d.wr && ((s_d.ph == PH_SETUP) || (s_d.ph == PH_DATA));
        end
        s_d.dq_out = (s_d.mux && (s_d.ph != PH_DATA)) ? s_d.addr[DATA_W-1:0] : s_d.wdata;
        s_d.be_n   = s_d.cs_n ? {BE_W{1'b1}} : ~s_d.be;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ph    <= PH_IDLE;
            s_q.cs_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.adv_n <= 1'b1;
            s_q.be_n  <= {BE_W{1'b1}};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.ph == PH_IDLE);
    assign rsp_done   = s_q.done;
    assign rsp_err    = s_q.err;
    assign rsp_rdata  = s_q.rdata;
    assign mem_cs_n   = s_q.cs_n;
    assign mem_oe_n   = s_q.oe_n;
    assign mem_we_n   = s_q.we_n;
    assign mem_adv_n  = s_q.adv_n;
    assign mem_be_n   = s_q.be_n;
    assign mem_addr   = s_q.addr;
    assign mem_dq_out = s_q.dq_out;
    assign mem_dq_oe  = s_q.dq_oe;

    // Output enable and write enable never overlap; reads leave the pins undriven.
    assert_oe_we_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    assert_read_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && !mem_cs_n));

    // Latch strobe only in shared-bus mode, with the pins driven.
    assert_adv_mux_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> (s_q.mux && mem_dq_oe && !mem_cs_n));

    // Releasing output enable coincides with the completion pulse.
    assert_done_at_oe_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> rsp_done);

    // A turnaround gap keeps the request side closed.
    assert_turn_blocks_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_err && (s_q.turn != '0)) |-> !req_ready);

    // Refused writes leave every strobe idle.
    assert_err_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_done && mem_cs_n && mem_we_n && req_ready));

    // An asserted wait keeps the data phase open.
    assert_wait_holds_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (s_q.ph == PH_DATA));

endmodule

// File: tb/amem_seq_top_test.sv
module amem_seq_top_test;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mux = 1'b0, cfg_wr_en = 1'b0, cfg_wait_en = 1'b0, cfg_wait_pol = 1'b0;
    logic [3:0] cfg_addr_setup = '0, cfg_addr_hold = '0, cfg_turnaround = '0;
    logic [7:0] cfg_data_setup = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic req_ready, rsp_done, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
    logic [1:0] mem_be_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_dq_out, mem_dq_in;
    logic mem_wait = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    // Device model: read data visible only while output enable is low.
    assign mem_dq_in = mem_oe_n ? 16'h0000 : (mem_addr[15:0] ^ 16'h5A3C);

    amem_seq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_mux(cfg_mux), .cfg_wr_en(cfg_wr_en), .cfg_wait_en(cfg_wait_en),
        .cfg_wait_pol(cfg_wait_pol), .cfg_addr_setup(cfg_addr_setup),
        .cfg_addr_hold(cfg_addr_hold), .cfg_data_setup(cfg_data_setup),
        .cfg_turnaround(cfg_turnaround),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_adv_n(mem_adv_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .mem_wait(mem_wait)
    );

    typedef struct packed {
        logic        mux;
        logic        wr;
        logic        wren;
        logic        wen;
        logic        pol;
        logic [3:0]  s;
        logic [3:0]  h;
        logic [7:0]  d;
        logic [3:0]  t;
        logic [3:0]  w;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [1:0]  be;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 4'd2, 4'd1, 8'd3,   4'd1,  4'd0, 16'h1234, 16'h0000, 2'b11},
        '{1'b0,1'b1,1'b1,1'b0,1'b0, 4'd1, 4'd1, 8'd2,   4'd0,  4'd0, 16'h0456, 16'hBEEF, 2'b01},
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 4'd3, 4'd2, 8'd4,   4'd2,  4'd0, 16'h789A, 16'h0000, 2'b11},
        '{1'b1,1'b1,1'b1,1'b0,1'b0, 4'd1, 4'd0, 8'd1,   4'd3,  4'd0, 16'h2222, 16'hCAFE, 2'b10},
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 4'd0, 4'd1, 8'd0,   4'd0,  4'd0, 16'h0F0F, 16'h0000, 2'b11},
        '{1'b0,1'b1,1'b0,1'b0,1'b0, 4'd2, 4'd1, 8'd2,   4'd2,  4'd0, 16'h3333, 16'h1111, 2'b11},
        '{1'b0,1'b0,1'b1,1'b1,1'b1, 4'd1, 4'd1, 8'd2,   4'd1,  4'd3, 16'h4444, 16'h0000, 2'b11},
        '{1'b0,1'b1,1'b1,1'b1,1'b0, 4'd2, 4'd1, 8'd1,   4'd0,  4'd2, 16'h5555, 16'hA5A5, 2'b11},
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 4'd1, 4'd1, 8'd2,   4'd0,  4'd4, 16'h6666, 16'h0000, 2'b11},
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 4'd15,4'd1, 8'd255, 4'd15, 4'd0, 16'h7777, 16'h0000, 2'b11}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int cs_c, oe_c, we_c, adv_c, rdy_c, guard, wl, hh, dd, st;
        logic latch_ok, wdat_ok, be_ok, seen_done, err_v;
        logic [15:0] rd;
        cs_c = 0; oe_c = 0; we_c = 0; adv_c = 0; rdy_c = 0; guard = 0;
        latch_ok = 1'b1; wdat_ok = 1'b1; be_ok = 1'b1; seen_done = 1'b0;
        err_v = 1'b0; rd = '0;
        wl = int'(v.w);
        @(negedge clk);
        cfg_mux = v.mux; cfg_wr_en = v.wren; cfg_wait_en = v.wen; cfg_wait_pol = v.pol;
        cfg_addr_setup = v.s; cfg_addr_hold = v.h; cfg_data_setup = v.d; cfg_turnaround = v.t;
        mem_wait = !v.pol;
        req_valid = 1'b1; req_write = v.wr; req_addr = {4'h0, v.addr};
        req_wdata = v.wdata; req_be = v.be;
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen_done && guard < 2000) begin
            if (!mem_cs_n) begin
                cs_c++;
                if (mem_be_n !== ~v.be) be_ok = 1'b0;
            end
            if (!mem_oe_n) oe_c++;
            if (!mem_we_n) begin
                we_c++;
                if (!mem_dq_oe || mem_dq_out !== v.wdata) wdat_ok = 1'b0;
            end
            if (!mem_adv_n) begin
                adv_c++;
                if (!mem_dq_oe || mem_dq_out !== v.addr) latch_ok = 1'b0;
            end
            if (rsp_done) begin
                seen_done = 1'b1;
                err_v = rsp_err;
                rd = rsp_rdata;
            end else begin
                if ((!mem_oe_n || !mem_we_n) && wl > 0) begin
                    mem_wait = v.pol;
                    wl--;
                end else begin
                    mem_wait = !v.pol;
                end
                guard++;
                @(negedge clk);
            end
        end
        mem_wait = !v.pol;
        while (!req_ready && rdy_c < 100) begin
            rdy_c++;
            @(negedge clk);
        end
        // Expected values from the requirements.
        hh = v.mux ? ((v.h == 0) ? 1 : int'(v.h)) : 0;
        dd = ((v.d == 0) ? 1 : int'(v.d)) + (v.wen ? int'(v.w) : 0);
        st = int'(v.s);
        chk("R5 done seen", {31'd0, seen_done}, 32'd1);
        if (v.wr && !v.wren) begin
            chk("R8 err flag", {31'd0, err_v}, 32'd1);
            chk("R8 cs_n stays high", cs_c, 0);
            chk("R8 we_n stays high", we_c, 0);
            chk("R8 ready not lowered", rdy_c, 0);
        end else begin
            chk("R8 no err", {31'd0, err_v}, 32'd0);
            chk("R2 cs_n low cycles", cs_c, st + hh + dd);
            chk("R3 adv_n low cycles", adv_c, v.mux ? st : 0);
            chk("R3 latched address on dq", {31'd0, latch_ok}, 32'd1);
            chk("R9 R4 oe_n low cycles", oe_c, v.wr ? 0 : dd);
            chk("R9 R4 we_n low cycles", we_c, v.wr ? dd : 0);
            chk("R6 byte lanes", {31'd0, be_ok}, 32'd1);
            chk("R7 turnaround cycles", rdy_c, int'(v.t));
            if (v.wr) chk("R6 write data on dq", {31'd0, wdat_ok}, 32'd1);
            else      chk("R5 read data", {16'd0, rd}, {16'd0, v.addr ^ 16'h5A3C});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cs_n", {31'd0, mem_cs_n}, 32'd1);
        chk("R1 oe_n/we_n/adv_n", {29'd0, mem_oe_n, mem_we_n, mem_adv_n}, 32'd7);
        chk("R1 dq_oe/done", {30'd0, mem_dq_oe, rsp_done}, 32'd0);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
        end

        // R8: back-to-back refused writes each give their own completion
        @(negedge clk);
        cfg_wr_en = 1'b0; req_valid = 1'b1; req_write = 1'b1;
        @(negedge clk);
        chk("R8 first refusal", {30'd0, rsp_done, rsp_err}, 32'd3);
        chk("R8 ready held", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 second refusal", {30'd0, rsp_done, rsp_err}, 32'd3);
        chk("R8 no strobe", {30'd0, mem_cs_n, mem_we_n}, 32'd3);

        // R1: reset asserted in the middle of a read data phase
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_mux = 1'b0; cfg_addr_setup = 4'd1; cfg_data_setup = 8'd20;
        cfg_wait_en = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h01234;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 pre-reset oe_n active", {31'd0, mem_oe_n}, 32'd0);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-access strobes", {28'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n}, 32'hF);
        chk("R1 mid-access ready", {30'd0, req_ready, mem_dq_oe}, 32'd2);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stays idle", {30'd0, mem_cs_n, req_ready}, 32'd3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule